// File: doc/BRIEF.md
# Cascaded Interrupt Pair Vector Logic

This block joins two eight-input interrupt controllers, one primary and one secondary, into a sixteen-line interrupt system. It takes each controller's current winning request (valid flag plus pin number) and its vector base. From these it builds the vector that the processor receives during an interrupt acknowledge. The priority logic inside each controller stays outside this block. The block only sees each controller's winner and drives back an accept strobe for the pin that was taken.

Each controller has a raised flag. When the secondary controller has a winner and its flag is clear, the flag is set and a one-cycle pulse goes out on the cascade line, which feeds input 2 of the primary controller. The primary controller works the same way and pulses the processor interrupt line. On an acknowledge, the primary's winner is looked at first. If that winner is the cascade pin, the secondary's winner supplies the vector. If no pin is eligible, pin 7 is reported as a spurious vector. The vector is then decoded against the secondary's base to decide which controller, or both, accepts the pin. Accepting clears the raised flag of each controller that accepts, so the next cycle evaluates the winners again.

Top module: `cpv_cascade_vec`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cpu_irq`, `casc_pulse`, `vec_vld`, `m_acc_vld` and `s_acc_vld` are 0 and `vec_out` is 0.
- R2: When `s_win_vld` is high and the secondary flag is clear, `casc_pulse` is 1 for exactly one cycle, on the cycle after the edge that sampled the request. No further pulse follows until the secondary has accepted a pin.
- R3: When `m_win_vld` is high and the primary flag is clear, `cpu_irq` is 1 for exactly one cycle, on the cycle after the edge that sampled the request. No further pulse follows until the primary has accepted a pin.
- R4: When `ack` is sampled high, `vec_vld` is 1 on the following cycle only. If the primary is raised and its winner pin p is not 2, `vec_out` equals `m_base`*8 + p.
- R5: If the primary is raised and its winner pin is 2 (the cascade pin), and the secondary has a winner pin q, `vec_out` equals `s_base`*8 + q.
- R6: The spurious pin is 7. If the primary is raised but has no winner, `vec_out` equals `m_base`*8 + 7. If the primary winner is pin 2 and the secondary has no winner, `vec_out` equals `s_base`*8 + 7.
- R7: If the primary is raised and `vec_out[7:3]` equals `s_base`, then in the same cycle as `vec_vld`: `s_acc_vld` is 1 with `s_acc_pin` = `vec_out[2:0]`, and `m_acc_vld` is 1 with `m_acc_pin` = 2.
- R8: If the primary is raised and `vec_out[7:3]` differs from `s_base`, then `m_acc_vld` is 1 with `m_acc_pin` = `vec_out[2:0]`, and `s_acc_vld` is 0.
- R9: An accept clears the raised flag of each accepting controller. If that controller's winner is still valid, its pulse (`cpu_irq` or `casc_pulse`) appears again one cycle after the accept strobe.
- R10: An `ack` while the primary is not raised returns `m_base`*8 + 7, asserts no accept strobe, and leaves both raised flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_win_vld | input | 1 | Primary controller has an eligible pin |
| m_win_pin | input | 3 | Primary controller's winning pin |
| s_win_vld | input | 1 | Secondary controller has an eligible pin |
| s_win_pin | input | 3 | Secondary controller's winning pin |
| m_base | input | 5 | Primary vector base (vector bits 7:3) |
| s_base | input | 5 | Secondary vector base (vector bits 7:3) |
| ack | input | 1 | Processor interrupt acknowledge request |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the processor |
| casc_pulse | output | 1 | One-cycle pulse to primary input 2 |
| vec_out | output | 8 | Acknowledged vector |
| vec_vld | output | 1 | `vec_out` is valid this cycle |
| m_acc_vld | output | 1 | Primary controller accepts a pin |
| m_acc_pin | output | 3 | Pin accepted by the primary |
| s_acc_vld | output | 1 | Secondary controller accepts a pin |
| s_acc_pin | output | 3 | Pin accepted by the secondary |

## Verification
The assertions assume that `ack` is a single-cycle strobe, and that the winner and base inputs are stable on the cycle `ack` is sampled. They also assume the two bases differ, so a primary vector can never be decoded as a secondary one. The stimulus applies a synchronous reset before every sweep case. It sets winners and bases on the falling edge, waits until the raise pulses have come out, then raises `ack` for one cycle. It draws base pairs only from distinct values.

// File: rtl/cpv_pkg.sv
package cpv_pkg;
    localparam int PIN_W  = 3;
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - PIN_W;
    localparam int NCTRL  = 2;   // index 0: primary, index 1: secondary

    typedef logic [PIN_W-1:0]  pin_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic vld;
        pin_t pin;
    } pinsel_t;

    function automatic vec_t make_vec(base_t b, pin_t p);
        return {b, p};
    endfunction

    function automatic logic vec_from_base(vec_t v, base_t b);
        return v[VEC_W-1:PIN_W] == b;
    endfunction

    function automatic pin_t vec_pin(vec_t v);
        return v[PIN_W-1:0];
    endfunction
endpackage

// File: rtl/cpv_raise_track.sv
module cpv_raise_track (
    input  logic clk,
    input  logic rst,
    input  logic win_vld,
    input  logic accept,
    output logic raised,
    output logic pulse
);
    logic raised_q, pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else if (accept) begin
            raised_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else if (!raised_q && win_vld) begin
            raised_q <= 1'b1;
            pulse_q  <= 1'b1;
        end else begin
            pulse_q  <= 1'b0;
        end
    end

    assign raised = raised_q;
    assign pulse  = pulse_q;
endmodule

// File: rtl/cpv_vec_pick.sv
module cpv_vec_pick
    import cpv_pkg::*;
#(
    parameter int CASC_PIN = 2,
    parameter int SPUR_PIN = 7
) (
    input  pinsel_t m_win,
    input  pinsel_t s_win,
    input  base_t   m_base,
    input  base_t   s_base,
    input  logic    m_armed,
    output vec_t    vec
);
    localparam pin_t CASC = pin_t'(CASC_PIN);
    localparam pin_t SPUR = pin_t'(SPUR_PIN);

    always_comb begin
        if (!m_armed || !m_win.vld) begin
            vec = make_vec(m_base, SPUR);
        end else if (m_win.pin == CASC) begin
            vec = s_win.vld ? make_vec(s_base, s_win.pin) : make_vec(s_base, SPUR);
        end else begin
            vec = make_vec(m_base, m_win.pin);
        end
    end
endmodule

// File: rtl/cpv_acc_route.sv
module cpv_acc_route
    import cpv_pkg::*;
#(
    parameter int CASC_PIN = 2
) (
    input  logic    go,
    input  vec_t    vec,
    input  base_t   s_base,
    output pinsel_t m_acc,
    output pinsel_t s_acc
);
    localparam pin_t CASC = pin_t'(CASC_PIN);

    always_comb begin
        m_acc = '0;
        s_acc = '0;
        if (go) begin
            if (vec_from_base(vec, s_base)) begin
                s_acc = '{vld: 1'b1, pin: vec_pin(vec)};
                m_acc = '{vld: 1'b1, pin: CASC};
            end else begin
                m_acc = '{vld: 1'b1, pin: vec_pin(vec)};
            end
        end
    end
endmodule

// File: rtl/cpv_cascade_vec.sv
module cpv_cascade_vec
    import cpv_pkg::*;
#(
    parameter int CASC_PIN = 2,
    parameter int SPUR_PIN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_win_vld,
    input  logic [PIN_W-1:0]  m_win_pin,
    input  logic              s_win_vld,
    input  logic [PIN_W-1:0]  s_win_pin,
    input  logic [BASE_W-1:0] m_base,
    input  logic [BASE_W-1:0] s_base,
    input  logic              ack,
    output logic              cpu_irq,
    output logic              casc_pulse,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_vld,
    output logic              m_acc_vld,
    output logic [PIN_W-1:0]  m_acc_pin,
    output logic              s_acc_vld,
    output logic [PIN_W-1:0]  s_acc_pin
);
    pinsel_t m_win, s_win, m_acc, s_acc;
    vec_t    vec_comb;
    logic    m_raised_w;

    logic [NCTRL-1:0] win_a, acc_a, raised_a, pulse_a;

    assign m_win = '{vld: m_win_vld, pin: m_win_pin};
    assign s_win = '{vld: s_win_vld, pin: s_win_pin};

    assign win_a[0] = m_win_vld;
    assign win_a[1] = s_win_vld;
    assign acc_a[0] = m_acc.vld;
    assign acc_a[1] = s_acc.vld;

    for (genvar g = 0; g < NCTRL; g++) begin : g_trk
        cpv_raise_track u_trk (
            .clk     (clk),
            .rst     (rst),
            .win_vld (win_a[g]),
            .accept  (acc_a[g]),
            .raised  (raised_a[g]),
            .pulse   (pulse_a[g])
        );
    end

    assign m_raised_w = raised_a[0];

    cpv_vec_pick #(.CASC_PIN(CASC_PIN), .SPUR_PIN(SPUR_PIN)) u_pick (
        .m_win   (m_win),
        .s_win   (s_win),
        .m_base  (m_base),
        .s_base  (s_base),
        .m_armed (m_raised_w),
        .vec     (vec_comb)
    );

    cpv_acc_route #(.CASC_PIN(CASC_PIN)) u_route (
        .go     (ack && m_raised_w),
        .vec    (vec_comb),
        .s_base (s_base),
        .m_acc  (m_acc),
        .s_acc  (s_acc)
    );

    vec_t    vec_q;
    logic    vld_q;
    pinsel_t m_acc_q, s_acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            vld_q   <= 1'b0;
            m_acc_q <= '0;
            s_acc_q <= '0;
        end else begin
            vld_q   <= ack;
            m_acc_q <= m_acc;
            s_acc_q <= s_acc;
            if (ack) vec_q <= vec_comb;
        end
    end

    assign cpu_irq    = pulse_a[0];
    assign casc_pulse = pulse_a[1];
    assign vec_out    = vec_q;
    assign vec_vld    = vld_q;
    assign m_acc_vld  = m_acc_q.vld;
    assign m_acc_pin  = m_acc_q.pin;
    assign s_acc_vld  = s_acc_q.vld;
    assign s_acc_pin  = s_acc_q.pin;
endmodule

// File: rtl/cpv_cascade_vec_chk.sv
module cpv_cascade_vec_chk
    import cpv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              m_win_vld,
    input logic [PIN_W-1:0]  m_win_pin,
    input logic              s_win_vld,
    input logic [PIN_W-1:0]  s_win_pin,
    input logic              ack,
    input logic              m_raised,
    input logic              cpu_irq,
    input logic              casc_pulse,
    input logic [VEC_W-1:0]  vec_out,
    input logic              vec_vld,
    input logic              m_acc_vld,
    input logic [PIN_W-1:0]  m_acc_pin,
    input logic              s_acc_vld,
    input logic [PIN_W-1:0]  s_acc_pin
);
    p_casc_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        casc_pulse |=> !casc_pulse);

    p_irq_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |=> !cpu_irq);

    p_vec_follows_ack_r4: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_vld);

    p_cascade_pick_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && m_raised && m_win_vld && m_win_pin == PIN_W'(2) && s_win_vld)
        |=> vec_out[PIN_W-1:0] == $past(s_win_pin));

    p_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !m_win_vld) |=> vec_out[PIN_W-1:0] == PIN_W'(7));

    p_both_accept_r7: assert property (@(posedge clk) disable iff (rst)
        s_acc_vld |-> (m_acc_vld && m_acc_pin == PIN_W'(2)
                       && s_acc_pin == vec_out[PIN_W-1:0] && vec_vld));

    p_acc_needs_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (m_acc_vld && !s_acc_vld) |-> (vec_vld && m_acc_pin == vec_out[PIN_W-1:0]));

    p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !m_raised) |=> (!m_acc_vld && !s_acc_vld));
endmodule

bind cpv_cascade_vec cpv_cascade_vec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_win_vld  (m_win_vld),
    .m_win_pin  (m_win_pin),
    .s_win_vld  (s_win_vld),
    .s_win_pin  (s_win_pin),
    .ack        (ack),
    .m_raised   (m_raised_w),
    .cpu_irq    (cpu_irq),
    .casc_pulse (casc_pulse),
    .vec_out    (vec_out),
    .vec_vld    (vec_vld),
    .m_acc_vld  (m_acc_vld),
    .m_acc_pin  (m_acc_pin),
    .s_acc_vld  (s_acc_vld),
    .s_acc_pin  (s_acc_pin)
);

// File: tb/sim_cpv_cascade_vec.sv
`timescale 1ns/1ps
module sim_cpv_cascade_vec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_win_vld = 1'b0, s_win_vld = 1'b0, ack = 1'b0;
    logic [2:0] m_win_pin = '0, s_win_pin = '0;
    logic [4:0] m_base = '0, s_base = '0;
    logic       cpu_irq, casc_pulse, vec_vld, m_acc_vld, s_acc_vld;
    logic [7:0] vec_out;
    logic [2:0] m_acc_pin, s_acc_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpv_cascade_vec u0 (
        .clk(clk), .rst(rst),
        .m_win_vld(m_win_vld), .m_win_pin(m_win_pin),
        .s_win_vld(s_win_vld), .s_win_pin(s_win_pin),
        .m_base(m_base), .s_base(s_base), .ack(ack),
        .cpu_irq(cpu_irq), .casc_pulse(casc_pulse),
        .vec_out(vec_out), .vec_vld(vec_vld),
        .m_acc_vld(m_acc_vld), .m_acc_pin(m_acc_pin),
        .s_acc_vld(s_acc_vld), .s_acc_pin(s_acc_pin)
    );

    task automatic check(input int got, input int exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ack = 1'b0; m_win_vld = 1'b0; s_win_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one sweep case: raise, acknowledge, check vector and accepts
    task automatic run_case(input bit mv, input int mp, input bit sv, input int sp,
                            input int mb, input int sb);
        int ev, ep, eb;
        do_reset();
        m_base = 5'(mb); s_base = 5'(sb);
        m_win_vld = mv; m_win_pin = 3'(mp);
        s_win_vld = sv; s_win_pin = 3'(sp);
        tick();
        check(int'(cpu_irq), int'(mv), "R3 raise pulse");
        check(int'(casc_pulse), int'(sv), "R2 cascade pulse");
        tick();
        check(int'(cpu_irq), 0, "R3 single pulse");
        check(int'(casc_pulse), 0, "R2 single pulse");
        @(negedge clk);
        ack = 1'b1;
        // expected vector
        if (!mv) begin eb = mb; ep = 7; end
        else if (mp == 2) begin eb = sb; ep = sv ? sp : 7; end
        else begin eb = mb; ep = mp; end
        ev = eb * 8 + ep;
        tick();
        check(int'(vec_vld), 1, "R4 vec_vld after ack");
        if (!mv) check(int'(vec_out), ev, "R10 idle ack vector");
        else if (mp != 2) check(int'(vec_out), ev, "R4 primary vector");
        else if (sv) check(int'(vec_out), ev, "R5 cascaded vector");
        else check(int'(vec_out), ev, "R6 secondary spurious");
        if (!mv) begin
            check(int'(m_acc_vld), 0, "R10 no primary accept");
            check(int'(s_acc_vld), 0, "R10 no secondary accept");
        end else if (eb == sb) begin
            check(int'(s_acc_vld), 1, "R7 secondary accept");
            check(int'(s_acc_pin), ep, "R7 secondary pin");
            check(int'(m_acc_vld), 1, "R7 primary cascade accept");
            check(int'(m_acc_pin), 2, "R7 primary pin 2");
        end else begin
            check(int'(m_acc_vld), 1, "R8 primary accept");
            check(int'(m_acc_pin), ep, "R8 primary pin");
            check(int'(s_acc_vld), 0, "R8 no secondary accept");
        end
        @(negedge clk);
        ack = 1'b0; m_win_vld = 1'b0; s_win_vld = 1'b0;
        tick();
        check(int'(vec_vld), 0, "R4 vec_vld one cycle");
        check(int'(m_acc_vld) + int'(s_acc_vld), 0, "R8 accept one cycle");
    endtask

    initial begin
        int mbs[3] = '{1, 4, 31};
        int sbs[3] = '{2, 14, 0};
        // R1: reset holds outputs low even with active inputs
        @(negedge clk);
        rst = 1'b1; m_win_vld = 1'b1; s_win_vld = 1'b1; ack = 1'b1; m_base = 5'd3;
        tick();
        tick();
        check(int'(cpu_irq) + int'(casc_pulse) + int'(vec_vld), 0, "R1 reset pulses");
        check(int'(m_acc_vld) + int'(s_acc_vld), 0, "R1 reset accepts");
        check(int'(vec_out), 0, "R1 reset vector");
        @(negedge clk);
        rst = 1'b0; m_win_vld = 1'b0; s_win_vld = 1'b0; ack = 1'b0;
        tick();
        check(int'(cpu_irq) + int'(casc_pulse) + int'(vec_vld), 0, "R1 first cycle after reset");

        // sweep
        for (int b = 0; b < 3; b++)
            for (int mv = 0; mv < 2; mv++)
                for (int sv = 0; sv < 2; sv++)
                    for (int mp = 0; mp < 8; mp++)
                        for (int sp = 0; sp < 8; sp++)
                            run_case(mv[0], mp, sv[0], sp, mbs[b], sbs[b]);

        // R9: primary-only accept, winner stays valid -> primary re-raises
        do_reset();
        m_base = 5'd9; s_base = 5'd10;
        m_win_vld = 1'b1; m_win_pin = 3'd5;
        tick(); tick();
        @(negedge clk); ack = 1'b1;
        tick();
        check(int'(m_acc_vld), 1, "R9 accept strobe");
        @(negedge clk); ack = 1'b0;
        tick();
        check(int'(cpu_irq), 1, "R9 primary re-raise");

        // R9: cascaded accept clears both flags
        do_reset();
        m_win_vld = 1'b1; m_win_pin = 3'd2; s_win_vld = 1'b1; s_win_pin = 3'd4;
        tick(); tick();
        @(negedge clk); ack = 1'b1;
        tick();
        check(int'(vec_out), 10 * 8 + 4, "R5 cascaded vector directed");
        @(negedge clk); ack = 1'b0;
        tick();
        check(int'(cpu_irq), 1, "R9 primary re-raise after cascade");
        check(int'(casc_pulse), 1, "R9 secondary re-raise");

        // R10: secondary raised, primary idle; ack must leave secondary raised
        do_reset();
        s_win_vld = 1'b1; s_win_pin = 3'd6;
        tick();
        check(int'(casc_pulse), 1, "R2 secondary raise directed");
        @(negedge clk); ack = 1'b1;
        tick();
        check(int'(vec_out), 9 * 8 + 7, "R10 spurious primary vector");
        check(int'(m_acc_vld) + int'(s_acc_vld), 0, "R10 no accept");
        @(negedge clk); ack = 1'b0;
        tick();
        check(int'(casc_pulse), 0, "R10 secondary flag kept");
        tick();
        check(int'(casc_pulse), 0, "R2 no repeat while raised");
        @(negedge clk); m_win_vld = 1'b1; m_win_pin = 3'd2;
        tick();
        check(int'(cpu_irq), 1, "R3 primary raise on cascade");
        @(negedge clk); ack = 1'b1;
        tick();
        check(int'(s_acc_vld), 1, "R7 secondary accept directed");
        check(int'(s_acc_pin), 6, "R7 secondary pin directed");
        @(negedge clk); ack = 1'b0;
        tick();
        check(int'(casc_pulse), 1, "R9 secondary re-raise after accept");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule